// File: doc/BRIEF.md
# Byte/Word FIFO Bridge with Self-Timed Flush

This block sits on an APB bus and joins it to a pair of 16-byte FIFOs: a transmit FIFO that software fills and a receive FIFO that software drains. One data register moves either a single byte or a 32-bit word per bus access. Which of the two it moves is chosen separately for each direction by the control register. Two ready flags tell software whether one full access unit can be moved right now. The same 8-bit control register also selects loopback, gates the interface, and starts a flush that clears both FIFOs over a fixed number of cycles.

On the line side, the transmit FIFO drains through a byte stream, `tx_out_*`. A byte leaves on any cycle in which `tx_out_valid` and `tx_out_ready` are both high. The receive FIFO fills from a byte stream, `rx_in_*`. A byte is taken on any cycle in which `rx_in_valid` and `rx_in_ready` are both high. The bridge applies back-pressure on the receive side by dropping `rx_in_ready` when the FIFO is full, during a flush, and in loopback. A sender must hold its data while ready is low. In loopback both streams are idle, and bytes are moved internally from the transmit FIFO to the receive FIFO.

The register map has two offsets: control at `paddr` 0x0 and data at `paddr` 0x4. Any other address reads 0 and ignores writes. `pready` is always high, so every access completes in its access phase.

Top module: `byte_fifo_bridge`

## Requirements
- R1: The control register resets to 0x20. A read at offset 0x0 returns loopback in bit 5, enable in bit 4, receive width in bit 3, transmit width in bit 2, and the flush-busy flag in both bit 1 and bit 0. Bits 31:6 always read 0.
- R2: While loopback (bit 5) is 1 and no flush runs, one byte moves from the transmit FIFO to the receive FIFO per cycle whenever the transmit FIFO is not empty and the receive FIFO is not full. In this mode `tx_out_valid` and `rx_in_ready` stay 0.
- R3: While enable (bit 4) is 0, `tx_rdy` is 0 and writes to the data register are dropped.
- R4: A read of the data register with `rx_rdy` high pops 1 byte into bits 7:0, with bits 31:8 at 0, when bit 3 is 0. When bit 3 is 1 it pops 4 bytes, with the oldest byte in bits 7:0 and the newest in bits 31:24.
- R5: `rx_rdy` is 1 exactly when no flush runs and the receive FIFO holds at least 1 byte (bit 3 = 0) or at least 4 bytes (bit 3 = 1).
- R6: `tx_rdy` is 1 exactly when enable is 1, no flush runs, and the transmit FIFO has room for at least 1 byte (bit 2 = 0) or 4 bytes (bit 2 = 1). A write with `tx_rdy` high pushes `pwdata[7:0]`, or all four bytes starting with bits 7:0.
- R7: A data access made while the matching ready flag is 0 changes no FIFO, and such a read returns 0.
- R8: Writing 1 to bit 0 starts a flush that lasts exactly 4 cycles, and bits 1 and 0 read 1 throughout it. Writing 0 to bit 0 starts nothing. Writing 1 during a flush does not extend it.
- R9: A flush leaves both FIFOs empty. During a flush, data accesses and both streams are ignored.
- R10: Outside loopback, `tx_out_valid` is 1 whenever the transmit FIFO is not empty, and `tx_out_data` shows its oldest byte. `rx_in_ready` is 1 whenever the receive FIFO holds fewer than 16 bytes. Neither holds during a flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write (1) or read (0) |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data, valid in access phase |
| pready | output | 1 | APB ready, always 1 |
| tx_rdy | output | 1 | One transmit access unit can be written |
| rx_rdy | output | 1 | One receive access unit can be read |
| tx_out_valid | output | 1 | Transmit stream byte available |
| tx_out_ready | input | 1 | Line side accepts a transmit byte |
| tx_out_data | output | 8 | Transmit stream byte |
| rx_in_valid | input | 1 | Line side offers a receive byte |
| rx_in_ready | output | 1 | Bridge accepts a receive byte |
| rx_in_data | input | 8 | Receive stream byte |

## Verification
A bad FIFO count shows up within one cycle as a ready flag set at the wrong fill level, because `tx_rdy`, `rx_rdy`, `tx_out_valid` and `rx_in_ready` are compared against a queue model on every clock. A bad pointer or byte-lane order shows up on the next data read or the next stream byte that reaches it. A flush timer that is off by one shows up as bits 1:0 of a control read that disagree with the model, or as ready flags that return one cycle early or late.

// File: rtl/bfb_pkg.sv
package bfb_pkg;
  // Per-direction and mode configuration, bit order matches control bits 5..2
  typedef struct packed {
    logic loopback;
    logic enable;
    logic rx_wide;
    logic tx_wide;
  } bfb_cfg_t;

  localparam int WORD_LANES = 4;
  localparam int BYTE_W     = 8;
endpackage

// File: rtl/bfb_ctrl.sv
module bfb_ctrl
  import bfb_pkg::*;
#(
  parameter int FLUSH_CYC = 4
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wr_en,
  input  bfb_cfg_t wr_cfg,
  input  logic     wr_flush,
  output bfb_cfg_t cfg,
  output logic     busy
);
  localparam int TW = (FLUSH_CYC > 1) ? $clog2(FLUSH_CYC) : 1;

  logic [TW-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg    <= '{loopback: 1'b1, enable: 1'b0, rx_wide: 1'b0, tx_wide: 1'b0};
      busy   <= 1'b0;
      remain <= '0;
    end else begin
      if (wr_en) cfg <= wr_cfg;
      if (busy) begin
        if (remain == '0) busy <= 1'b0;
        else              remain <= remain - 1'b1;
      end else if (wr_en && wr_flush) begin
        busy   <= 1'b1;
        remain <= TW'(FLUSH_CYC - 1);
      end
    end
  end
endmodule

// File: rtl/bfb_fifo.sv
module bfb_fifo #(
  parameter int DEPTH     = 16,
  parameter int PUSH_LN   = 1,
  parameter int POP_LN    = 1,
  localparam int AW       = $clog2(DEPTH),
  localparam int CW       = $clog2(DEPTH + 1),
  localparam int PUW      = $clog2(PUSH_LN + 1),
  localparam int POW      = $clog2(POP_LN + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clear,
  input  logic [PUW-1:0]       push_n,
  input  logic [PUSH_LN*8-1:0] push_data,
  input  logic [POW-1:0]       pop_n,
  output logic [POP_LN*8-1:0]  head,
  output logic [CW-1:0]        count
);
  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wp, rp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; count <= '0;
    end else if (clear) begin
      wp <= '0; rp <= '0; count <= '0;
    end else begin
      wp    <= wp + AW'(push_n);
      rp    <= rp + AW'(pop_n);
      count <= count + CW'(push_n) - CW'(pop_n);
    end
  end

  always_ff @(posedge clk) begin
    if (!clear) begin
      for (int i = 0; i < PUSH_LN; i++) begin
        if (i < int'(push_n)) mem[wp + AW'(i)] <= push_data[i*8 +: 8];
      end
    end
  end

  for (genvar g = 0; g < POP_LN; g++) begin : g_head
    assign head[g*8 +: 8] = mem[rp + AW'(g)];
  end
endmodule

// File: rtl/byte_fifo_bridge.sv
module byte_fifo_bridge
  import bfb_pkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int FLUSH_CYC = 4,
  parameter int ADDR_W    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  output logic              pready,
  output logic              tx_rdy,
  output logic              rx_rdy,
  output logic              tx_out_valid,
  input  logic              tx_out_ready,
  output logic [7:0]        tx_out_data,
  input  logic              rx_in_valid,
  output logic              rx_in_ready,
  input  logic [7:0]        rx_in_data
);
  localparam int CW  = $clog2(DEPTH + 1);
  localparam int NW  = $clog2(WORD_LANES + 1);
  localparam logic [ADDR_W-1:0] OFS_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFS_DATA = ADDR_W'(4);

  bfb_cfg_t      cfg;
  logic          busy;
  logic          acc, hit_ctrl, hit_data;
  logic [CW-1:0] tx_cnt, rx_cnt, tx_free;
  logic [NW-1:0] need_tx, need_rx, tx_push_n, rx_pop_n;
  logic [7:0]    tx_head;
  logic [WORD_LANES*8-1:0] rx_head;
  logic          lb_move, tx_pop, rx_push;
  logic [7:0]    rx_push_data;

  assign pready   = 1'b1;
  assign acc      = psel & penable;
  assign hit_ctrl = (paddr == OFS_CTRL);
  assign hit_data = (paddr == OFS_DATA);

  bfb_ctrl #(.FLUSH_CYC(FLUSH_CYC)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (acc & pwrite & hit_ctrl),
    .wr_cfg   (bfb_cfg_t'(pwdata[5:2])),
    .wr_flush (pwdata[0]),
    .cfg      (cfg),
    .busy     (busy)
  );

  // Access-unit sizing and ready flags
  assign need_tx = cfg.tx_wide ? NW'(WORD_LANES) : NW'(1);
  assign need_rx = cfg.rx_wide ? NW'(WORD_LANES) : NW'(1);
  assign tx_free = CW'(DEPTH) - tx_cnt;
  assign tx_rdy  = cfg.enable & ~busy & (tx_free >= CW'(need_tx));
  assign rx_rdy  = ~busy & (rx_cnt >= CW'(need_rx));

  assign tx_push_n = (acc & pwrite & hit_data & tx_rdy) ? need_tx : '0;
  assign rx_pop_n  = (acc & ~pwrite & hit_data & rx_rdy) ? need_rx : '0;

  // Line side: stream ports outside loopback, internal move inside it
  assign lb_move      = cfg.loopback & ~busy & (tx_cnt != '0) & (rx_cnt != CW'(DEPTH));
  assign tx_out_valid = ~cfg.loopback & ~busy & (tx_cnt != '0);
  assign tx_out_data  = tx_head;
  assign rx_in_ready  = ~cfg.loopback & ~busy & (rx_cnt != CW'(DEPTH));
  assign tx_pop       = lb_move | (tx_out_valid & tx_out_ready);
  assign rx_push      = lb_move | (rx_in_valid & rx_in_ready);
  assign rx_push_data = lb_move ? tx_head : rx_in_data;

  bfb_fifo #(.DEPTH(DEPTH), .PUSH_LN(WORD_LANES), .POP_LN(1)) u_txq (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (busy),
    .push_n    (tx_push_n),
    .push_data (pwdata),
    .pop_n     (tx_pop),
    .head      (tx_head),
    .count     (tx_cnt)
  );

  bfb_fifo #(.DEPTH(DEPTH), .PUSH_LN(1), .POP_LN(WORD_LANES)) u_rxq (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (busy),
    .push_n    (rx_push),
    .push_data (rx_push_data),
    .pop_n     (rx_pop_n),
    .head      (rx_head),
    .count     (rx_cnt)
  );

  always_comb begin
    prdata = '0;
    if (acc && !pwrite) begin
      if (hit_ctrl)
        prdata = {24'b0, 2'b00, cfg, busy, busy};
      else if (hit_data && rx_rdy)
        prdata = cfg.rx_wide ? rx_head : {24'b0, rx_head[7:0]};
    end
  end
endmodule

// File: rtl/bfb_checker.sv
module bfb_checker #(
  parameter int DEPTH     = 16,
  parameter int FLUSH_CYC = 4,
  parameter int CW        = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          loopback,
  input logic          enable,
  input logic          tx_rdy,
  input logic          tx_out_valid,
  input logic          rx_in_ready,
  input logic          ctrl_rd,
  input logic [31:0]   prdata,
  input logic [CW-1:0] tx_cnt,
  input logic [CW-1:0] rx_cnt
);
  int unsigned run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run <= 0;
    else if (busy) run <= run + 1;
    else           run <= 0;
  end

  p_resv_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_rd |-> prdata[31:6] == '0);

  p_lb_streams_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    loopback |-> (!tx_out_valid && !rx_in_ready));

  p_disabled_no_tx_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> !tx_rdy);

  p_flush_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> run == FLUSH_CYC);

  p_flush_empties_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (tx_cnt == '0 && rx_cnt == '0));

  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_cnt <= CW'(DEPTH)) && (rx_cnt <= CW'(DEPTH)));
endmodule

bind byte_fifo_bridge bfb_checker #(.DEPTH(DEPTH), .FLUSH_CYC(FLUSH_CYC), .CW(CW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .busy         (busy),
  .loopback     (cfg.loopback),
  .enable       (cfg.enable),
  .tx_rdy       (tx_rdy),
  .tx_out_valid (tx_out_valid),
  .rx_in_ready  (rx_in_ready),
  .ctrl_rd      (psel & penable & ~pwrite & hit_ctrl),
  .prdata       (prdata),
  .tx_cnt       (tx_cnt),
  .rx_cnt       (rx_cnt)
);

// File: tb/test_byte_fifo_bridge.sv
module test_byte_fifo_bridge;
  localparam int DEPTH = 16;
  localparam int FLUSH = 4;

  logic clk = 0, rst_n = 0;
  logic psel = 0, penable = 0, pwrite = 0;
  logic [3:0] paddr = 0;
  logic [31:0] pwdata = 0, prdata;
  logic pready, tx_rdy, rx_rdy, tx_out_valid, rx_in_ready;
  logic tx_out_ready = 0, rx_in_valid = 0;
  logic [7:0] tx_out_data, rx_in_data = 0;

  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  byte_fifo_bridge #(.DEPTH(DEPTH), .FLUSH_CYC(FLUSH), .ADDR_W(4)) i_byte_fifo_bridge (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .tx_rdy(tx_rdy), .rx_rdy(rx_rdy), .tx_out_valid(tx_out_valid),
    .tx_out_ready(tx_out_ready), .tx_out_data(tx_out_data),
    .rx_in_valid(rx_in_valid), .rx_in_ready(rx_in_ready), .rx_in_data(rx_in_data));

  // Reference model
  logic [7:0] txq[$], rxq[$];
  bit m_lb = 1, m_en = 0, m_rxw = 0, m_txw = 0;
  int busy_cnt = 0;

  function automatic bit m_busy(); return busy_cnt > 0; endfunction
  function automatic bit m_txrdy();
    return m_en && !m_busy() && (DEPTH - txq.size()) >= (m_txw ? 4 : 1);
  endfunction
  function automatic bit m_rxrdy();
    return !m_busy() && rxq.size() >= (m_rxw ? 4 : 1);
  endfunction
  function automatic bit m_txv(); return !m_lb && !m_busy() && txq.size() > 0; endfunction
  function automatic bit m_rxr(); return !m_lb && !m_busy() && rxq.size() < DEPTH; endfunction
  function automatic logic [31:0] m_prdata();
    logic [31:0] v = 0;
    if (psel && penable && !pwrite) begin
      if (paddr == 0) v = {26'b0, m_lb, m_en, m_rxw, m_txw, m_busy(), m_busy()};
      else if (paddr == 4 && m_rxrdy()) begin
        if (m_rxw) v = {rxq[3], rxq[2], rxq[1], rxq[0]};
        else       v = {24'b0, rxq[0]};
      end
    end
    return v;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare();
    check("R6 tx_rdy", 32'(tx_rdy), 32'(m_txrdy()));
    check("R5 rx_rdy", 32'(rx_rdy), 32'(m_rxrdy()));
    check("R10 tx_out_valid", 32'(tx_out_valid), 32'(m_txv()));
    if (m_txv()) check("R10 tx_out_data", 32'(tx_out_data), 32'(txq[0]));
    check("R10 rx_in_ready", 32'(rx_in_ready), 32'(m_rxr()));
    check("R4 prdata", prdata, m_prdata());
  endtask

  task automatic update();
    bit busy0 = m_busy();
    bit acc = psel && penable;
    bit lbm = m_lb && !busy0 && txq.size() > 0 && rxq.size() < DEPTH;
    bit txs = m_txv() && tx_out_ready;
    bit rxs = m_rxr() && rx_in_valid;
    bit wr_ok = acc && pwrite && paddr == 4 && m_txrdy();
    bit rd_ok = acc && !pwrite && paddr == 4 && m_rxrdy();
    if (rd_ok) repeat (m_rxw ? 4 : 1) void'(rxq.pop_front());
    if (lbm) rxq.push_back(txq.pop_front());
    if (txs) void'(txq.pop_front());
    if (rxs) rxq.push_back(rx_in_data);
    if (wr_ok) for (int i = 0; i < (m_txw ? 4 : 1); i++) txq.push_back(pwdata[i*8 +: 8]);
    if (busy0) begin
      txq.delete(); rxq.delete(); busy_cnt--;
    end
    if (acc && pwrite && paddr == 0) begin
      {m_lb, m_en, m_rxw, m_txw} = pwdata[5:2];
      if (pwdata[0] && !busy0) busy_cnt = FLUSH;
    end
  endtask

  task automatic tick();
    #1; compare();
    @(posedge clk); update();
    @(negedge clk);
  endtask

  task automatic apb_wr(logic [3:0] a, logic [31:0] d);
    psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d; tick();
    penable = 1; tick();
    psel = 0; penable = 0;
  endtask

  task automatic apb_rd(logic [3:0] a, output logic [31:0] d);
    psel = 1; penable = 0; pwrite = 0; paddr = a; tick();
    penable = 1; #1 d = prdata; tick();
    psel = 0; penable = 0;
  endtask

  task automatic idle(int n);
    repeat (n) tick();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1: reset value
    apb_rd(0, d); check("R1 reset ctrl", d, 32'h20);
    // R3: disabled write dropped (loopback would otherwise deliver it)
    check("R3 tx_rdy low when disabled", 32'(tx_rdy), 0);
    apb_wr(4, 32'hAA); idle(3);
    check("R3 nothing reached rx", 32'(rx_rdy), 0);
    apb_rd(4, d); check("R7 read when empty", d, 0);

    // R2: loopback byte mode
    apb_wr(0, 32'h30);
    apb_rd(0, d); check("R1 ctrl readback", d, 32'h30);
    apb_wr(4, 32'h11); apb_wr(4, 32'h22); apb_wr(4, 32'h33);
    idle(2);
    apb_rd(4, d); check("R2 loopback byte0", d, 32'h11);
    apb_rd(4, d); check("R2 loopback byte1", d, 32'h22);
    apb_rd(4, d); check("R4 byte read", d, 32'h33);

    // R4/R6: word mode both directions
    apb_wr(0, 32'h3C);
    apb_wr(4, 32'hDDCCBBAA); idle(5);
    apb_rd(4, d); check("R4 word order", d, 32'hDDCCBBAA);
    // R5/R7: three bytes are not a word
    apb_wr(0, 32'h38);
    apb_wr(4, 32'h01); apb_wr(4, 32'h02); apb_wr(4, 32'h03); idle(2);
    check("R5 rx_rdy needs 4", 32'(rx_rdy), 0);
    apb_rd(4, d); check("R7 word read not ready", d, 0);
    apb_wr(4, 32'h04); idle(2);
    apb_rd(4, d); check("R4 mixed width", d, 32'h04030201);

    // R10/R6: normal mode, fill tx with words
    apb_wr(0, 32'h14);
    for (int i = 0; i < 4; i++) apb_wr(4, 32'h10203040 + i);
    check("R6 tx full", 32'(tx_rdy), 0);
    apb_wr(4, 32'hFFFFFFFF);   // R7: dropped
    for (int i = 0; i < 40; i++) begin
      tx_out_ready = i[0] | i[2];
      rx_in_valid = i[1] | i[0]; rx_in_data = 8'(i * 7);
      tick();
    end
    tx_out_ready = 0; rx_in_valid = 0;
    check("R10 rx full stalls", 32'(rx_in_ready), 0);

    // R8/R9: flush
    apb_wr(4, 32'h5);
    apb_wr(0, 32'h11);
    apb_rd(0, d); check("R8 busy bits", d, 32'h13);
    apb_wr(0, 32'h11);          // R8: no restart
    idle(2);
    apb_rd(0, d); check("R8 flush done", d, 32'h10);
    check("R9 rx empty", 32'(rx_rdy), 0);
    check("R9 tx empty", 32'(tx_out_valid), 0);
    apb_wr(0, 32'h10); apb_rd(0, d); check("R8 write 0 no flush", d, 32'h10);

    // Mixed random traffic checked against the model each cycle
    for (int i = 0; i < 600; i++) begin
      int r = $urandom_range(0, 9);
      tx_out_ready = 1'($urandom); rx_in_valid = 1'($urandom);
      rx_in_data = 8'($urandom);
      if (r == 0) apb_wr(0, {26'b0, 4'($urandom), 1'b0, ($urandom_range(0, 7) == 0)});
      else if (r < 4) apb_wr(4, $urandom);
      else if (r < 7) apb_rd(4, d);
      else if (r == 7) apb_rd(8, d);
      else tick();
    end
    finish_run();
  end
endmodule